// File: doc/BRIEF.md
# Post-Alignment Pattern Capture Checker

This block watches the received octet stream of one serial lane, after character decoding, together with the flag that marks each octet as a control character. It waits for the initial lane alignment sequence to finish. It then joins each pair of data octets into a 16-bit sample and compares every sample with the word that the selected transmitter test mode should produce. It reports a pass or a sticky fail, the index of the first sample that differed, and a copy of the first few samples received.

The checker arms on the alignment character that ends the last alignment multiframe. It takes the very next data octet as the high byte of sample 0. A one-shot user pattern that is followed by an endless zero stream therefore shows up in the capture registers, so a designer can tell whether the leading words were transmitted or were lost in the receiver. A control character other than the alignment character during the data phase means the link has failed. The checker then stops, raises a link error, and keeps that state until reset.

Top module: `lane_pattern_capture`

## Requirements
- R1: After a synchronous active-low reset, `armed`, `pass`, `fail`, `link_err` and every `cap_valid` bit are 0.
- R2: The checker arms after it sees the 4th alignment character (octet 0x7C with `rx_is_ctrl`=1) since reset or since the last lane-sync character. A non-control 0x7C does not count. Other control characters do not count and have no effect before arming.
- R3: Before arming, a lane-sync character (0xBC with `rx_is_ctrl`=1) clears the count of alignment characters.
- R4: After arming, data octets pair into samples. The first octet of a pair is bits 15:8 and the second is bits 7:0. Sample 0 is built from the first data octet after the arming alignment character.
- R5: In `test_mode` 2'b00, and also in 2'b11, the expected sample is 0x5555 at even indices and 0xAAAA at odd indices.
- R6: In `test_mode` 2'b01, the expected sample at index i is user word (i mod 4). User word k sits in `user_words` bits 16k+15 to 16k.
- R7: In `test_mode` 2'b10, the expected sample is user word i for i below 4 and 0x0000 for every later index.
- R8: The first mismatching sample sets `fail`, which stays set, and stores its index in `first_err_idx`. Later mismatches change neither.
- R9: `pass` rises when the number of consecutive matching samples from index 0 reaches `pass_len`, where `pass_len` is at least 1. A mismatch clears `pass`. `pass` and `fail` are never both 1, and a `pass_len` of 0 never gives a pass.
- R10: Samples 0 to 3 are latched into `cap_words` slots 0 to 3 (slot k at bits 16k+15 to 16k), whether they match or not. Each slot sets its `cap_valid` bit, and the slot then holds its value.
- R11: An alignment control character received during the data phase is dropped. It does not break or shift sample assembly.
- R12: Any other control character during the data phase clears `armed` and sets `link_err`. Both states hold until reset, and no later sample affects `pass`, `fail` or the captures.
- R13: An octet presented with `rx_valid`=0 is ignored, whatever its value or control flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive octet clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Octet on `rx_octet` is valid this cycle |
| rx_octet | input | 8 | Decoded received octet |
| rx_is_ctrl | input | 1 | Octet is a control character |
| test_mode | input | 2 | 00/11 checkerboard, 01 looping user words, 10 one-shot user words |
| user_words | input | 64 | Four 16-bit user pattern words, word 0 in the low bits |
| pass_len | input | 16 | Matching samples needed for a pass |
| armed | output | 1 | Alignment done, data phase active |
| link_err | output | 1 | Unexpected control character in data phase (sticky) |
| pass | output | 1 | Required run of matching samples seen |
| fail | output | 1 | A sample mismatched (sticky) |
| first_err_idx | output | 16 | Index of the first mismatching sample |
| cap_words | output | 64 | First four received samples |
| cap_valid | output | 4 | Capture slot filled |

## Verification
The assertions check on every cycle that arming follows only an alignment control character, that a link error has an illegal control character in the data phase as its cause and leaves the checker disarmed, and that `fail`, `first_err_idx`, `link_err` and filled capture slots never change once set. They also check that pass and fail never occur together. Only the bench scenarios can show that the right sample values are expected in each mode. They also show that an interrupted alignment sequence delays arming, that the one-shot words land in the capture slots ahead of the zero stream, that a missing one-shot prefix reports index 0, and that gaps and mid-sample alignment characters leave assembly intact.

// File: rtl/pcc_pkg.sv
// Shared types and character codes for the pattern capture checker.
// Assumes octets arrive already decoded, with a separate control flag.
package pcc_pkg;
    typedef enum logic [1:0] {
        MODE_CHECKER     = 2'b00,
        MODE_USER_LOOP   = 2'b01,
        MODE_USER_ONCE   = 2'b10,
        MODE_CHECKER_ALT = 2'b11
    } pcc_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'b00,
        ST_DATA = 2'b01,
        ST_HALT = 2'b10
    } pcc_state_e;

    localparam logic [7:0] CH_ALIGN     = 8'h7C;
    localparam logic [7:0] CH_LANE_SYNC = 8'hBC;
endpackage

// File: rtl/pcc_align_det.sv
// Alignment tracker: counts alignment control characters and switches to the
// data phase after ALIGN_MF of them. A lane-sync character before arming
// restarts the count. Any non-alignment control character in the data phase
// halts the tracker for good and raises link_err.
// Assumes the octet stream is not scrambled.
module pcc_align_det
    import pcc_pkg::*;
#(
    parameter int ALIGN_MF = 4,
    parameter int OCT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oct_v,
    input  logic [OCT_W-1:0] oct,
    input  logic             is_ctrl,
    output logic             armed,
    output logic             link_err,
    output logic             data_v
);
    localparam int CNT_W = $clog2(ALIGN_MF + 1);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(ALIGN_MF - 1);

    pcc_state_e       state;
    logic [CNT_W-1:0] a_cnt;
    logic             is_align;
    logic             is_sync;

    // Classify the current octet as one of the two characters of interest.
    always_comb begin
        is_align = oct_v && is_ctrl && (oct == OCT_W'(CH_ALIGN));
        is_sync  = oct_v && is_ctrl && (oct == OCT_W'(CH_LANE_SYNC));
    end

    // Phase state machine with alignment character counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            a_cnt    <= '0;
            link_err <= 1'b0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (is_align) begin
                        if (a_cnt == LAST_A) begin
                            state <= ST_DATA;
                            a_cnt <= '0;
                        end else begin
                            a_cnt <= a_cnt + 1'b1;
                        end
                    end else if (is_sync) begin
                        a_cnt <= '0;
                    end
                end
                ST_DATA: begin
                    if (oct_v && is_ctrl && !is_align) begin
                        state    <= ST_HALT;
                        link_err <= 1'b1;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // Data octets go to the assembler only in the data phase.
    assign armed  = (state == ST_DATA);
    assign data_v = armed && oct_v && !is_ctrl;
endmodule

// File: rtl/pcc_sample_asm.sv
// Sample assembler: shifts data octets in most-significant first and emits
// one registered sample every SAMP_W/OCT_W octets. The clear input drops a
// partly built sample. Assumes SAMP_W is a multiple of OCT_W and at least 2x.
module pcc_sample_asm #(
    parameter int OCT_W  = 8,
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              data_v,
    input  logic [OCT_W-1:0]  oct,
    output logic              samp_v,
    output logic [SAMP_W-1:0] samp
);
    localparam int OPS  = SAMP_W / OCT_W;
    localparam int PH_W = (OPS > 2) ? $clog2(OPS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OPS - 1);

    logic [SAMP_W-1:0] acc;
    logic [SAMP_W-1:0] shifted;
    logic [PH_W-1:0]   phase;

    // Next accumulator value with the new octet in the low bits.
    assign shifted = {acc[SAMP_W-OCT_W-1:0], oct};

    // Octet phase tracking and sample output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            phase  <= '0;
            samp   <= '0;
            samp_v <= 1'b0;
        end else begin
            samp_v <= 1'b0;
            if (clear) begin
                phase <= '0;
            end else if (data_v) begin
                acc <= shifted;
                if (phase == PH_LAST) begin
                    phase  <= '0;
                    samp   <= shifted;
                    samp_v <= 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcc_expect_gen.sv
// Expected-word generator: maps a sample index and test mode to the word the
// transmitter should send. Purely combinational. Assumes NUP is a power of 2.
module pcc_expect_gen
    import pcc_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int NUP    = 4,
    parameter int IDX_W  = 16
) (
    input  pcc_mode_e             mode,
    input  logic [IDX_W-1:0]      idx,
    input  logic [NUP*SAMP_W-1:0] user_words,
    output logic [SAMP_W-1:0]     exp_word
);
    localparam int SEL_W = (NUP > 1) ? $clog2(NUP) : 1;
    localparam logic [SAMP_W-1:0] CHK_EVEN = {(SAMP_W/2){2'b01}};
    localparam logic [SAMP_W-1:0] CHK_ODD  = {(SAMP_W/2){2'b10}};

    logic [SAMP_W-1:0] up_arr [NUP];
    logic [SAMP_W-1:0] up_sel;

    // Unpack the flat user word bus.
    for (genvar k = 0; k < NUP; k++) begin : g_unpack
        assign up_arr[k] = user_words[k*SAMP_W +: SAMP_W];
    end

    assign up_sel = up_arr[idx[SEL_W-1:0]];

    // Select the expected word for the active mode.
    always_comb begin
        case (mode)
            MODE_USER_LOOP: exp_word = up_sel;
            MODE_USER_ONCE: exp_word = (idx < IDX_W'(NUP)) ? up_sel : '0;
            default:        exp_word = idx[0] ? CHK_ODD : CHK_EVEN;
        endcase
    end
endmodule

// File: rtl/lane_pattern_capture.sv
// Top level of the post-alignment pattern capture checker for one lane.
// Arms after the alignment sequence, builds samples, compares them with the
// expected test pattern, keeps pass/fail/first-error state and the first
// NCAP samples. Assumes test_mode, user_words and pass_len are static
// while a test runs.
module lane_pattern_capture
    import pcc_pkg::*;
#(
    parameter int OCT_W    = 8,
    parameter int SAMP_W   = 16,
    parameter int ALIGN_MF = 4,
    parameter int NUP      = 4,
    parameter int NCAP     = 4,
    parameter int IDX_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [OCT_W-1:0]       rx_octet,
    input  logic                   rx_is_ctrl,
    input  logic [1:0]             test_mode,
    input  logic [NUP*SAMP_W-1:0]  user_words,
    input  logic [IDX_W-1:0]       pass_len,
    output logic                   armed,
    output logic                   link_err,
    output logic                   pass,
    output logic                   fail,
    output logic [IDX_W-1:0]       first_err_idx,
    output logic [NCAP*SAMP_W-1:0] cap_words,
    output logic [NCAP-1:0]        cap_valid
);
    logic              data_v;
    logic              samp_v;
    logic [SAMP_W-1:0] samp;
    logic [SAMP_W-1:0] exp_word;
    logic [IDX_W-1:0]  samp_idx;
    logic [IDX_W:0]    run_len;
    logic              hit;

    pcc_align_det #(
        .ALIGN_MF (ALIGN_MF),
        .OCT_W    (OCT_W)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .oct_v    (rx_valid),
        .oct      (rx_octet),
        .is_ctrl  (rx_is_ctrl),
        .armed    (armed),
        .link_err (link_err),
        .data_v   (data_v)
    );

    pcc_sample_asm #(
        .OCT_W  (OCT_W),
        .SAMP_W (SAMP_W)
    ) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!armed),
        .data_v (data_v),
        .oct    (rx_octet),
        .samp_v (samp_v),
        .samp   (samp)
    );

    pcc_expect_gen #(
        .SAMP_W (SAMP_W),
        .NUP    (NUP),
        .IDX_W  (IDX_W)
    ) u_exp (
        .mode       (pcc_mode_e'(test_mode)),
        .idx        (samp_idx),
        .user_words (user_words),
        .exp_word   (exp_word)
    );

    // Match flag and run length including the current sample.
    assign hit     = (samp == exp_word);
    assign run_len = {1'b0, samp_idx} + 1'b1;

    // Sample index, sticky fail, first error index and pass tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_idx      <= '0;
            pass          <= 1'b0;
            fail          <= 1'b0;
            first_err_idx <= '0;
        end else if (samp_v) begin
            if (samp_idx != '1) begin
                samp_idx <= samp_idx + 1'b1;
            end
            if (hit) begin
                if (!fail && (run_len == {1'b0, pass_len})) begin
                    pass <= 1'b1;
                end
            end else if (!fail) begin
                fail          <= 1'b1;
                pass          <= 1'b0;
                first_err_idx <= samp_idx;
            end
        end
    end

    // One capture slot per leading sample index.
    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        logic [SAMP_W-1:0] cap_r;
        logic              cap_v;

        // Latch sample g once, whatever the compare result.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_r <= '0;
                cap_v <= 1'b0;
            end else if (samp_v && !cap_v && (samp_idx == IDX_W'(g))) begin
                cap_r <= samp;
                cap_v <= 1'b1;
            end
        end

        assign cap_words[g*SAMP_W +: SAMP_W] = cap_r;
        assign cap_valid[g]                  = cap_v;
    end
endmodule

// File: rtl/lane_pattern_capture_chk.sv
// Property checker for lane_pattern_capture, attached with bind below.
// Observes top-level ports only.
module lane_pattern_capture_chk #(
    parameter int OCT_W  = 8,
    parameter int SAMP_W = 16,
    parameter int NCAP   = 4,
    parameter int IDX_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_valid,
    input logic [OCT_W-1:0]       rx_octet,
    input logic                   rx_is_ctrl,
    input logic                   armed,
    input logic                   link_err,
    input logic                   pass,
    input logic                   fail,
    input logic [IDX_W-1:0]       first_err_idx,
    input logic [NCAP*SAMP_W-1:0] cap_words,
    input logic [NCAP-1:0]        cap_valid
);
    // R1: reset clears all status outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!armed && !pass && !fail && !link_err && (cap_valid == '0)));

    // R2: arming only follows a valid alignment control character.
    a_r2_arm_on_align: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(rx_valid && rx_is_ctrl && (rx_octet == OCT_W'(8'h7C))));

    // R8: fail is sticky.
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    // R8: first error index holds once fail is set.
    a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> $stable(first_err_idx));

    // R9: pass and fail are exclusive.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R12: link error is sticky and leaves the checker disarmed.
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> (link_err && !armed));

    // R12: link error is caused by a non-alignment control in the data phase.
    a_r12_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err) |-> $past(armed && rx_valid && rx_is_ctrl &&
                                  (rx_octet != OCT_W'(8'h7C))));

    // R10: a filled capture slot stays filled and keeps its value.
    for (genvar g = 0; g < NCAP; g++) begin : g_cap_chk
        a_r10_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            cap_valid[g] |=> (cap_valid[g] && $stable(cap_words[g*SAMP_W +: SAMP_W])));
    end
endmodule

bind lane_pattern_capture lane_pattern_capture_chk #(
    .OCT_W  (OCT_W),
    .SAMP_W (SAMP_W),
    .NCAP   (NCAP),
    .IDX_W  (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_octet      (rx_octet),
    .rx_is_ctrl    (rx_is_ctrl),
    .armed         (armed),
    .link_err      (link_err),
    .pass          (pass),
    .fail          (fail),
    .first_err_idx (first_err_idx),
    .cap_words     (cap_words),
    .cap_valid     (cap_valid)
);

// File: tb/lane_pattern_capture_bench.sv
// Self-checking bench: directed corner cases plus seeded random runs.
module lane_pattern_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_octet = 8'h00;
    logic        rx_is_ctrl = 1'b0;
    logic [1:0]  test_mode = 2'b00;
    logic [63:0] user_words = '0;
    logic [15:0] pass_len = 16'd1;
    logic        armed, link_err, pass, fail;
    logic [15:0] first_err_idx;
    logic [63:0] cap_words;
    logic [3:0]  cap_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit garbage_ctrl = 1'b0;
    logic [15:0] smem [0:63];

    lane_pattern_capture u_lane_pattern_capture (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_octet (rx_octet),
        .rx_is_ctrl (rx_is_ctrl), .test_mode (test_mode), .user_words (user_words),
        .pass_len (pass_len), .armed (armed), .link_err (link_err), .pass (pass),
        .fail (fail), .first_err_idx (first_err_idx), .cap_words (cap_words),
        .cap_valid (cap_valid)
    );

    always #2.5ns clk = ~clk;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(logic [1:0] m, int i);
        logic [15:0] u;
        u = user_words[(i % 4)*16 +: 16];
        case (m)
            2'b01:   return u;
            2'b10:   return (i < 4) ? u : 16'h0000;
            default: return (i % 2 == 1) ? 16'hAAAA : 16'h5555;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(logic [7:0] o, logic c);
        if (($urandom % 5) == 0) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_octet = garbage_ctrl ? 8'h1C : 8'($urandom);
            rx_is_ctrl = garbage_ctrl ? 1'b1 : 1'($urandom);
        end
        @(negedge clk);
        rx_valid = 1'b1; rx_octet = o; rx_is_ctrl = c;
    endtask

    task automatic idle();
        @(negedge clk);
        rx_valid = 1'b0; rx_is_ctrl = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_ilas(int lead_k, int n_mf);
        for (int k = 0; k < lead_k; k++) send(8'hBC, 1'b1);
        for (int m = 0; m < n_mf; m++) begin
            send(8'h1C, 1'b1);
            for (int j = 1; j < 63; j++) begin
                if (m == 1 && j == 1) send(8'h9C, 1'b1);
                else if (j % 8 == 0) send(8'h7C, 1'b0);
                else send(8'($urandom), 1'b0);
            end
            send(8'h7C, 1'b1);
        end
    endtask

    task automatic build(int n);
        for (int i = 0; i < n; i++) smem[i] = exp_word(test_mode, i);
    endtask

    task automatic send_samples(int n, int a_at, int lerr_at);
        for (int i = 0; i < n; i++) begin
            if (i == lerr_at) send(8'h1C, 1'b1);
            send(smem[i][15:8], 1'b0);
            if (i == a_at) send(8'h7C, 1'b1);
            send(smem[i][7:0], 1'b0);
        end
    endtask

    // Compare every output with the model of R4-R12.
    task automatic check_run(string tag, int n_eff, int err, logic lerr);
        logic fexp, pexp;
        fexp = (err >= 0) && (err < n_eff);
        pexp = !fexp && (pass_len != 0) && (n_eff >= int'(pass_len));
        check({tag, " R8"}, "fail", fail, fexp);
        if (fexp) check({tag, " R8"}, "first_err_idx", first_err_idx, err);
        check({tag, " R9"}, "pass", pass, pexp);
        check({tag, " R12"}, "link_err", link_err, lerr);
        check({tag, " R2"}, "armed", armed, !lerr);
        for (int i = 0; i < 4; i++) begin
            check({tag, " R10"}, "cap_valid", cap_valid[i], i < n_eff);
            if (i < n_eff) check({tag, " R4 R10"}, "cap_word", cap_words[i*16 +: 16], smem[i]);
        end
    endtask

    task automatic run(string tag, logic [1:0] m, int n, int plen, int err, int a_at, int lerr_at);
        int n_eff;
        test_mode = m; pass_len = 16'(plen);
        do_reset();
        build(n);
        if (err >= 0) begin
            smem[err] = smem[err] ^ 16'(16'h0100 | $urandom);
            if (err + 3 < n) smem[err+3] = ~smem[err+3];
        end
        send_ilas(2, 4);
        send_samples(n, a_at, lerr_at);
        idle();
        n_eff = (lerr_at >= 0 && lerr_at < n) ? lerr_at : n;
        check_run(tag, n_eff, err, lerr_at >= 0 && lerr_at < n);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        user_words = {16'hFEDC, 16'h3B1B, 16'h7654, 16'h3B1B};

        // R1: reset state.
        do_reset();
        @(negedge clk);
        check("R1", "armed", armed, 1'b0);
        check("R1", "pass/fail/link_err", {pass, fail, link_err}, 3'b000);
        check("R1", "cap_valid", cap_valid, 4'h0);

        // R2 R3: interrupted alignment sequence delays arming.
        send_ilas(4, 3); idle();
        check("R2", "armed after 3 align chars", armed, 1'b0);
        send_ilas(1, 1); idle();
        check("R3", "armed after sync reset and 1 align char", armed, 1'b0);
        send_ilas(0, 3); idle();
        check("R2", "armed after 4 align chars", armed, 1'b1);

        // R5: checkerboard, full pass.
        run("R5", 2'b00, 20, 20, -1, -1, -1);
        // R5: alternate checkerboard code.
        run("R5 alt", 2'b11, 9, 9, -1, -1, -1);
        // R6: looping user words.
        run("R6", 2'b01, 16, 16, -1, -1, -1);
        // R7: one-shot user words then zeros; captures hold user words.
        run("R7", 2'b10, 12, 12, -1, -1, -1);
        for (int i = 0; i < 4; i++)
            check("R7 R10", "one-shot capture", cap_words[i*16 +: 16], user_words[i*16 +: 16]);

        // R7 R8: transmitter skipped the one-shot words (zeros only).
        test_mode = 2'b10; pass_len = 16'd8;
        do_reset();
        for (int i = 0; i < 10; i++) smem[i] = 16'h0000;
        send_ilas(2, 4); send_samples(10, -1, -1); idle();
        check_run("R7 missing prefix", 10, 0, 1'b0);

        // R9: pass_len beyond the run, and zero pass_len.
        run("R9 long", 2'b01, 6, 10, -1, -1, -1);
        run("R9 zero", 2'b00, 6, 0, -1, -1, -1);
        // R9: mismatch after pass clears it.
        run("R9 late err", 2'b00, 12, 4, 8, -1, -1);
        // R11: alignment char mid-sample is dropped.
        run("R11", 2'b01, 10, 10, -1, 3, -1);
        // R12: link error stops processing; later errors ignored.
        run("R12", 2'b01, 12, 12, 7, -1, 5);

        // R13: invalid octets carrying control codes are ignored.
        garbage_ctrl = 1'b1;
        run("R13", 2'b00, 24, 24, -1, -1, -1);
        garbage_ctrl = 1'b0;

        // Random runs across all modes.
        for (int it = 0; it < 24; it++) begin
            int n, pl, er;
            user_words = {$urandom, $urandom};
            n  = 4 + int'($urandom % 37);
            pl = 1 + int'($urandom % (n + 4));
            er = (($urandom % 2) == 0) ? -1 : int'($urandom % n);
            run("R5 R6 R7 R8 R9 rnd", 2'($urandom), n, pl, er,
                (($urandom % 3) == 0) ? int'($urandom % n) : -1, -1);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule